// File: doc/BRIEF.md
# Power-Down Hold and Pin Keeper

This block sits between a row of device pins and the internal logic. Each pin arrives with a value and a flag that says whether something outside is actually driving it. When a pin floats, a per-pin bus keeper can keep reporting the level it last saw driven, so the internal logic never sees an undefined input. The block also registers the internal output values and output enables on their way back to the pins.

A configuration bit turns on a pin-controlled power-down. With it on, a high level on the power-down pin freezes the registered inputs, the keeper state, the output values and the output enables. Pin changes are ignored for as long as the pin stays high. The power-down pin shares one pin position, and while the option is on that position reads as zero and its output enable is forced off. A separate idle counter raises a standby flag after a programmable number of clock edges with no change on the inputs. The first change clears the flag.

Top module: `pin_hold_wrap`

## Requirements
- R1: With the power-down option off (cfg_pd_en=0), pd_pin has no effect: inputs and outputs keep updating, and pin position PD_IDX behaves like any other pin.
- R2: With the option on, a high pd_pin sampled at a rising clock edge enters power-down at that edge. The registers keep their earlier values from that edge on.
- R3: While powered down, in_held, out_val and out_en do not change, whatever core_out and core_oe do.
- R4: While powered down, pin transitions neither update the keeper nor count as input activity. A standby flag that is already set stays set.
- R5: With the option on, in_held[PD_IDX] reads 0 and out_en[PD_IDX] is 0 (default PD_IDX=3).
- R6: A pin with its keeper on (cfg_keep_en[i]=1) and its driven flag low reports the value last sampled while its flag was high.
- R7: A pin with its keeper off and its driven flag low reads 0.
- R8: standby is high when the count of consecutive clock edges without an input change reaches cfg_idle_limit. The count saturates. Any change clears the count at that edge, so standby drops.
- R9: At the first rising edge with pd_pin low, in_held, out_val and out_en take the current pin and core values. No intermediate value appears.
- R10: After reset, in_held, out_val and out_en are 0, and standby is 0 for a nonzero cfg_idle_limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pd_en | input | 1 | Power-down option enable |
| cfg_keep_en | input | N | Per-pin keeper enable |
| cfg_idle_limit | input | CW | Quiet edges before standby |
| pd_pin | input | 1 | Power-down request, active high |
| pin_in | input | N | Sampled pin levels |
| pin_drv | input | N | Per-pin driven flag (1 = driven) |
| core_out | input | N | Internal output values |
| core_oe | input | N | Internal output enables |
| in_held | output | N | Held input values to the logic |
| out_val | output | N | Held output values to the pins |
| out_en | output | N | Held output enables to the pins |
| standby | output | 1 | No-activity standby flag |

## Verification
The standby assertions assume that cfg_idle_limit stays constant while the flag is being judged. The keeper assertion assumes that cfg_keep_en and cfg_pd_en are quasi-static. The stimulus changes configuration only in directed phases that are separated by clock edges, and it never changes the limit after reset. The assertions do not constrain pin values or driven flags, so the vector table combines floating, partly driven and fully driven pins freely, both inside and outside power-down.

// File: rtl/pin_hold_wrap.sv
module pin_hold_wrap #(
  parameter int N      = 4,
  parameter int PD_IDX = 3,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pd_en,
  input  logic [N-1:0]  cfg_keep_en,
  input  logic [CW-1:0] cfg_idle_limit,
  input  logic          pd_pin,
  input  logic [N-1:0]  pin_in,
  input  logic [N-1:0]  pin_drv,
  input  logic [N-1:0]  core_out,
  input  logic [N-1:0]  core_oe,
  output logic [N-1:0]  in_held,
  output logic [N-1:0]  out_val,
  output logic [N-1:0]  out_en,
  output logic          standby
);
  localparam logic [N-1:0] PD_BIT = {{(N-1){1'b0}}, 1'b1} << PD_IDX;

  logic [N-1:0]  kept_q, in_q, out_q, oe_q, pin_mask, eff;
  logic [CW-1:0] cnt_q;
  logic          hold, act;

  assign hold     = cfg_pd_en & pd_pin;
  assign pin_mask = cfg_pd_en ? ~PD_BIT : '1;
  assign eff      = ((pin_drv & pin_in) | (~pin_drv & cfg_keep_en & kept_q)) & pin_mask;
  assign act      = !hold && (eff != in_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kept_q <= '0;
      in_q   <= '0;
      out_q  <= '0;
      oe_q   <= '0;
    end else if (!hold) begin
      kept_q <= (pin_drv & pin_in) | (~pin_drv & kept_q);
      in_q   <= eff;
      out_q  <= core_out;
      oe_q   <= core_oe;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt_q <= '0;
    else if (act)        cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;

  assign in_held = in_q;
  assign out_val = out_q;
  assign out_en  = oe_q & pin_mask;
  assign standby = cnt_q >= cfg_idle_limit;

  // R2, R3: a sampled power-down request freezes every held register
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(in_q) && $stable(out_q) && $stable(oe_q)));

  // R8: an input change drops the standby flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (!standby || cfg_idle_limit == '0));

  // R4, R8: without activity an asserted standby stays asserted
  a_r8_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && standby) |=> (standby || !$stable(cfg_idle_limit)));

  for (genvar i = 0; i < N; i++) begin : g_keep
    // R6: a floating pin with its keeper on reports the kept level
    a_r6_keeper: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !pin_drv[i] && cfg_keep_en[i] && !(cfg_pd_en && i == PD_IDX))
      |=> (in_q[i] == $past(kept_q[i])));
  end
endmodule

// File: tb/sim_pin_hold_wrap.sv
`timescale 1ns/1ps
module sim_pin_hold_wrap;
  logic clk = 0, rst_n = 0;
  logic cfg_pd_en, pd_pin;
  logic [3:0] cfg_keep_en, pin_in, pin_drv, core_out, core_oe;
  logic [7:0] cfg_idle_limit;
  logic [3:0] in_held, out_val, out_en;
  logic standby;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pin_hold_wrap u0 (.clk, .rst_n, .cfg_pd_en, .cfg_keep_en, .cfg_idle_limit,
    .pd_pin, .pin_in, .pin_drv, .core_out, .core_oe,
    .in_held, .out_val, .out_en, .standby);

  // {pd, drv, pin, core_out, core_oe, exp_in, exp_out, exp_oe}, nibble each
  localparam logic [31:0] VEC [7] = '{
    32'h0F5AF5A7, 32'h00031531, 32'h01231431, 32'h1F3CF431,
    32'h10000431, 32'h0F266266, 32'h00F98290 };

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic step(logic pd, logic [3:0] drv, logic [3:0] pin, logic [3:0] co, logic [3:0] oe);
    pd_pin = pd; pin_drv = drv; pin_in = pin; core_out = co; core_oe = oe;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_pd_en = 1; cfg_keep_en = 4'hF; cfg_idle_limit = 8'd3;
    pd_pin = 0; pin_in = 0; pin_drv = 0; core_out = 0; core_oe = 0;
    repeat (3) @(negedge clk);
    chk("R10 in_held", in_held, 0);
    chk("R10 out_val", out_val, 0);
    chk("R10 out_en", out_en, 0);
    chk("R10 standby", standby, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R5 R6 via table
    for (int k = 0; k < 7; k++) begin
      logic [31:0] v;
      v = VEC[k];
      step(v[28], v[27:24], v[23:20], v[19:16], v[15:12]);
      chk($sformatf("R6/R3/R5 vec%0d in", k), in_held, v[11:8]);
      chk($sformatf("R3/R2 vec%0d out", k), out_val, v[7:4]);
      chk($sformatf("R5/R3 vec%0d oe", k), out_en, v[3:0]);
    end

    // R8 standby counting
    step(0, 4'hF, 4'h1, 4'h0, 4'h0);
    chk("R8 activity clears", standby, 0);
    step(0, 4'hF, 4'h1, 4'h0, 4'h0);
    step(0, 4'hF, 4'h1, 4'h0, 4'h0);
    chk("R8 two quiet edges", standby, 0);
    step(0, 4'hF, 4'h1, 4'h0, 4'h0);
    chk("R8 limit reached", standby, 1);

    // R4 pin changes during hold ignored
    step(1, 4'hF, 4'h6, 4'h5, 4'h5);
    chk("R4 standby kept", standby, 1);
    chk("R4 in frozen", in_held, 4'h1);
    step(1, 4'h0, 4'h2, 4'h5, 4'h5);
    chk("R3 out frozen", out_val, 4'h0);

    // R9 release
    step(0, 4'hF, 4'h6, 4'h5, 4'h5);
    chk("R9 in on release", in_held, 4'h6);
    chk("R9 out on release", out_val, 4'h5);
    chk("R9 oe on release", out_en, 4'h5);
    chk("R8 release change", standby, 0);

    // R7 keeper off
    cfg_keep_en = 4'hE;
    step(0, 4'hF, 4'h1, 4'h0, 4'h0);
    chk("R7 driven", in_held, 4'h1);
    step(0, 4'h0, 4'h0, 4'h0, 4'h0);
    chk("R7 float reads 0", in_held, 4'h0);
    cfg_keep_en = 4'hF;

    // R1 option off
    cfg_pd_en = 0;
    step(1, 4'hF, 4'h8, 4'h4, 4'hF);
    chk("R1 in not frozen", in_held, 4'h8);
    chk("R1 out not frozen", out_val, 4'h4);
    chk("R1 oe full", out_en, 4'hF);
    cfg_pd_en = 1;
    step(0, 4'hF, 4'h8, 4'h4, 4'hF);
    chk("R5 pd bit masked in", in_held, 4'h0);
    chk("R5 pd bit masked oe", out_en, 4'h7);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule